// File: doc/BRIEF.md
# Command-Mode Read Data Multiplexer for a Parallel NOR Flash Model

This block produces the data returned by a read of a parallel NOR flash that uses the two-unlock-cycle command protocol. The command state machine sits outside the block and presents the command byte currently pending. From that byte the block decides which source answers the read: the array contents, the manufacturer and device identifier words, the status byte used for completion polling, or the CFI query table. The array storage and the query table live elsewhere. The block reaches them through lookup ports. The array side presents the four bytes starting at the read address. The query side is a combinational index-in, byte-out port.

A read strobe captures the address, the access size, the byte order and all source values. The assembled word appears on the output one clock later, with a valid flag. Two more one-cycle pulses come out alongside the data. The first marks a status read, so the busy logic can flip its toggle bit. The second marks a read taken under a command byte the block does not recognise, so the command logic can return to array mode. The device bus width is a parameter. It sets how far the byte address is shifted to form the register offset used for identifier and query lookups.

Top module: `flash_rdmux`

## Requirements
- R1: While reset is asserted and after its release, before any read, `rd_data` is 0 and `rd_valid`, `stat_rd_pulse` and `cmd_reset_req` are 0.
- R2: A read strobe in one cycle gives `rd_valid` high, with the new `rd_data`, in the next cycle. A cycle without a strobe gives `rd_valid` low in the next cycle, and `rd_data` keeps its last value.
- R3: The register offset is `rd_addr[7:0]` shifted right by 1 when DEV_BYTES is 2, by 2 when it is 4, and not shifted when it is 1. `cfi_idx` always shows this offset.
- R4: With command 0x00 or 0x80 the read returns array data. `arr_bytes[8k+7:8k]` holds the byte at address `rd_addr+k`. `rd_size` 0 reads 1 byte, 1 reads 2 bytes, and 2 or 3 reads 4 bytes. With `big_end` 0 the lowest address is the least significant byte. With `big_end` 1 it is the most significant byte. Unused upper bits are 0.
- R5: With command 0x90, offset 0x00 returns `id_w0` and offset 0x01 returns `id_w1`, each zero-extended. Offset 0x02 returns 0.
- R6: With command 0x90, offsets 0x0E and 0x0F return `id_w2` and `id_w3`, zero-extended. When the selected word has 0xFF in its low byte, the array data of R4 is returned instead.
- R7: With command 0x90, every offset not named in R5 or R6 returns the array data of R4.
- R8: With command 0xA0, 0x10 or 0x30 the read returns `status_byte` zero-extended, and `stat_rd_pulse` is high for exactly the cycle that data is valid. Under any other command it stays low.
- R9: With command 0x98 the read returns `cfi_byte` zero-extended when the offset is at most 0x52 (CFI_LAST), and 0 when the offset is larger.
- R10: Any command byte not listed in R4, R5, R8 or R9 returns the array data of R4, and `cmd_reset_req` is high for the cycle that data is valid. Under listed commands it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| big_end | input | 1 | 1 assembles multi-byte array reads big-endian |
| cur_cmd | input | 8 | Pending command byte from the command logic |
| arr_bytes | input | 32 | Array bytes at rd_addr+0 to +3, lane k in bits 8k+7:8k |
| id_w0 | input | 16 | Identifier word at offset 0x00 |
| id_w1 | input | 16 | Identifier word at offset 0x01 |
| id_w2 | input | 16 | Identifier word at offset 0x0E |
| id_w3 | input | 16 | Identifier word at offset 0x0F |
| status_byte | input | 8 | Current status byte |
| cfi_idx | output | 8 | Query table index (register offset) |
| cfi_byte | input | 8 | Query table byte at cfi_idx |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data was updated by the previous strobe |
| stat_rd_pulse | output | 1 | The valid data came from a status read |
| cmd_reset_req | output | 1 | The valid data was read under an unknown command |

## Verification
Array reads are swept over all 256 low addresses, every access size and both byte orders. The array model gives each address a distinct byte, so a lane swap, a wrong byte count or a missing zero-extension changes the word. Identifier mode is swept over every address twice: once with identifier words whose low bytes are not 0xFF, and once with words that end in 0xFF. The first pass separates the identifier offsets from the array fallback. The second shows that the 0xFF fallback does not leak to neighbouring offsets. Query mode is swept over every address to find the exact range edge, where offset 0x52 still reads the table and 0x53 reads zero. All 256 command bytes are then tried at one address, which separates the recognised codes from the reset-requesting ones and shows that the status strobe fires only for the three status codes.

// File: rtl/flash_rdmux_pkg.sv
package flash_rdmux_pkg;

  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_ERSETUP = 8'h80;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_CHIPER  = 8'h10;
  localparam logic [7:0] CMD_SECTER  = 8'h30;
  localparam logic [7:0] CMD_QUERY   = 8'h98;

  typedef enum logic [2:0] {
    MD_ARRAY  = 3'd0,
    MD_IDENT  = 3'd1,
    MD_STATUS = 3'd2,
    MD_QUERY  = 3'd3,
    MD_BAD    = 3'd4
  } rd_mode_e;

  function automatic rd_mode_e decode_mode(input logic [7:0] cmd);
    case (cmd)
      CMD_READ, CMD_ERSETUP:           decode_mode = MD_ARRAY;
      CMD_IDENT:                       decode_mode = MD_IDENT;
      CMD_PROG, CMD_CHIPER, CMD_SECTER: decode_mode = MD_STATUS;
      CMD_QUERY:                       decode_mode = MD_QUERY;
      default:                         decode_mode = MD_BAD;
    endcase
  endfunction

endpackage

// File: rtl/flash_rd_offset.sv
module flash_rd_offset #(
  parameter int DEV_BYTES = 2
) (
  input  logic [7:0] addr_lo,
  output logic [7:0] reg_off
);
  generate
    if (DEV_BYTES == 4) begin : g_x32
      assign reg_off = {2'b00, addr_lo[7:2]};
    end else if (DEV_BYTES == 2) begin : g_x16
      assign reg_off = {1'b0, addr_lo[7:1]};
    end else begin : g_x8
      assign reg_off = addr_lo;
    end
  endgenerate
endmodule

// File: rtl/flash_rd_array_pack.sv
module flash_rd_array_pack (
  input  logic [31:0] lanes,
  input  logic [1:0]  size,
  input  logic        big,
  output logic [31:0] word
);
  always_comb begin
    case (size)
      2'd0:    word = {24'h0, lanes[7:0]};
      2'd1:    word = big ? {16'h0, lanes[7:0], lanes[15:8]}
                          : {16'h0, lanes[15:8], lanes[7:0]};
      default: word = big ? {lanes[7:0], lanes[15:8], lanes[23:16], lanes[31:24]}
                          : lanes;
    endcase
  end
endmodule

// File: rtl/flash_rd_ident.sv
module flash_rd_ident (
  input  logic [7:0]  reg_off,
  input  logic [15:0] w0,
  input  logic [15:0] w1,
  input  logic [15:0] w2,
  input  logic [15:0] w3,
  input  logic [31:0] arr_word,
  output logic [31:0] word
);
  logic [15:0] ext_sel;

  always_comb begin
    ext_sel = reg_off[0] ? w3 : w2;
    case (reg_off)
      8'h00:        word = {16'h0, w0};
      8'h01:        word = {16'h0, w1};
      8'h02:        word = 32'h0;
      8'h0E, 8'h0F: word = (ext_sel[7:0] == 8'hFF) ? arr_word : {16'h0, ext_sel};
      default:      word = arr_word;
    endcase
  end
endmodule

// File: rtl/flash_rdmux.sv
module flash_rdmux
  import flash_rdmux_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         DEV_BYTES = 2,
  parameter logic [7:0] CFI_LAST  = 8'h52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  input  logic              big_end,
  input  logic [7:0]        cur_cmd,
  input  logic [31:0]       arr_bytes,
  input  logic [15:0]       id_w0,
  input  logic [15:0]       id_w1,
  input  logic [15:0]       id_w2,
  input  logic [15:0]       id_w3,
  input  logic [7:0]        status_byte,
  output logic [7:0]        cfi_idx,
  input  logic [7:0]        cfi_byte,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              stat_rd_pulse,
  output logic              cmd_reset_req
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic [7:0]  reg_off;
  logic [31:0] arr_word;
  logic [31:0] id_word;
  rd_mode_e    mode;

  flash_rd_offset #(.DEV_BYTES(DEV_BYTES)) u_off (
    .addr_lo (rd_addr[7:0]),
    .reg_off (reg_off)
  );

  flash_rd_array_pack u_pack (
    .lanes (arr_bytes),
    .size  (rd_size),
    .big   (big_end),
    .word  (arr_word)
  );

  flash_rd_ident u_id (
    .reg_off  (reg_off),
    .w0       (id_w0),
    .w1       (id_w1),
    .w2       (id_w2),
    .w3       (id_w3),
    .arr_word (arr_word),
    .word     (id_word)
  );

  assign cfi_idx = reg_off;
  assign mode    = decode_mode(cur_cmd);

  logic [31:0] data_d;
  logic        stat_d;
  logic        rst_req_d;

  always_comb begin
    stat_d    = 1'b0;
    rst_req_d = 1'b0;
    case (mode)
      MD_IDENT:  data_d = id_word;
      MD_STATUS: begin
        data_d = {24'h0, status_byte};
        stat_d = 1'b1;
      end
      MD_QUERY:  data_d = (reg_off > CFI_LAST) ? 32'h0 : {24'h0, cfi_byte};
      MD_BAD: begin
        data_d    = arr_word;
        rst_req_d = 1'b1;
      end
      default:   data_d = arr_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_valid      <= 1'b0;
      stat_rd_pulse <= 1'b0;
      cmd_reset_req <= 1'b0;
    end else begin
      rd_valid      <= rd_en;
      stat_rd_pulse <= rd_en & stat_d;
      cmd_reset_req <= rd_en & rst_req_d;
    end
  end

endmodule

// File: rtl/flash_rdmux_chk.sv
module flash_rdmux_chk #(
  parameter int         ADDR_W    = 16,
  parameter int         DEV_BYTES = 2,
  parameter logic [7:0] CFI_LAST  = 8'h52
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        cur_cmd,
  input logic [7:0]        status_byte,
  input logic [7:0]        cfi_idx,
  input logic [31:0]       rd_data,
  input logic              rd_valid,
  input logic              stat_rd_pulse,
  input logic              cmd_reset_req
);
  localparam int SH = (DEV_BYTES == 4) ? 2 : ((DEV_BYTES == 2) ? 1 : 0);

  logic [7:0] off_c;
  logic       is_stat;
  logic       is_known;
  assign off_c    = rd_addr[7:0] >> SH;
  assign is_stat  = (cur_cmd == 8'hA0) || (cur_cmd == 8'h10) || (cur_cmd == 8'h30);
  assign is_known = is_stat || (cur_cmd == 8'h00) || (cur_cmd == 8'h80)
                    || (cur_cmd == 8'h90) || (cur_cmd == 8'h98);

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

  // R3
  offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfi_idx == off_c);

  // R5
  id_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cur_cmd == 8'h90 && off_c == 8'h02) |=> (rd_data == 32'h0));

  // R8
  stat_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_stat) |=> (stat_rd_pulse && rd_data == {24'h0, $past(status_byte)}));

  // R8
  stat_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_pulse |-> rd_valid);

  // R9
  cfi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cur_cmd == 8'h98 && off_c > CFI_LAST) |=> (rd_data == 32'h0));

  // R10
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (cmd_reset_req == !$past(is_known)));

endmodule

bind flash_rdmux flash_rdmux_chk #(
  .ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES), .CFI_LAST(CFI_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .cur_cmd(cur_cmd), .status_byte(status_byte), .cfi_idx(cfi_idx),
  .rd_data(rd_data), .rd_valid(rd_valid), .stat_rd_pulse(stat_rd_pulse),
  .cmd_reset_req(cmd_reset_req)
);

// File: tb/flash_rdmux_test.sv
module flash_rdmux_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [1:0]    rd_size;
  logic          big_end;
  logic [7:0]    cur_cmd;
  logic [31:0]   arr_bytes;
  logic [15:0]   id_w0, id_w1, id_w2, id_w3;
  logic [7:0]    status_byte;
  logic [7:0]    cfi_idx;
  logic [7:0]    cfi_byte;
  logic [31:0]   rd_data;
  logic          rd_valid, stat_rd_pulse, cmd_reset_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic logic [7:0] mem_b(input logic [AW-1:0] a);
    mem_b = (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h5A;
  endfunction

  assign arr_bytes = {mem_b(rd_addr + 16'd3), mem_b(rd_addr + 16'd2),
                      mem_b(rd_addr + 16'd1), mem_b(rd_addr)};
  assign cfi_byte  = cfi_idx * 8'd3 + 8'd1;

  flash_rdmux #(.ADDR_W(AW), .DEV_BYTES(2), .CFI_LAST(8'h52)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_size(rd_size), .big_end(big_end), .cur_cmd(cur_cmd),
    .arr_bytes(arr_bytes), .id_w0(id_w0), .id_w1(id_w1), .id_w2(id_w2),
    .id_w3(id_w3), .status_byte(status_byte), .cfi_idx(cfi_idx),
    .cfi_byte(cfi_byte), .rd_data(rd_data), .rd_valid(rd_valid),
    .stat_rd_pulse(stat_rd_pulse), .cmd_reset_req(cmd_reset_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] arr_exp(input logic [AW-1:0] a, input logic [1:0] sz,
                                          input logic be);
    int n;
    logic [31:0] w;
    n = (sz == 2'd0) ? 1 : ((sz == 2'd1) ? 2 : 4);
    w = 32'h0;
    for (int k = 0; k < n; k++) begin
      if (be) w = w | (32'(mem_b(a + AW'(k))) << (8 * (n - 1 - k)));
      else    w = w | (32'(mem_b(a + AW'(k))) << (8 * k));
    end
    return w;
  endfunction

  function automatic logic [31:0] read_exp(input logic [7:0] cmd, input logic [AW-1:0] a,
                                           input logic [1:0] sz, input logic be);
    int off;
    logic [15:0] w;
    off = a[7:0] / 2;
    case (cmd)
      8'h90: begin
        if (off == 0) return {16'h0, id_w0};
        if (off == 1) return {16'h0, id_w1};
        if (off == 2) return 32'h0;
        if (off == 14 || off == 15) begin
          w = (off == 14) ? id_w2 : id_w3;
          if (w[7:0] == 8'hFF) return arr_exp(a, sz, be);
          return {16'h0, w};
        end
        return arr_exp(a, sz, be);
      end
      8'hA0, 8'h10, 8'h30: return {24'h0, status_byte};
      8'h98: return (off > 82) ? 32'h0 : 32'((off * 3 + 1) % 256);
      default: return arr_exp(a, sz, be);
    endcase
  endfunction

  task automatic do_read(input string req, input logic [7:0] cmd, input logic [AW-1:0] a,
                         input logic [1:0] sz, input logic be);
    logic [31:0] e;
    logic st_e, rq_e;
    @(negedge clk);
    cur_cmd = cmd; rd_addr = a; rd_size = sz; big_end = be; rd_en = 1'b1;
    e = read_exp(cmd, a, sz, be);
    st_e = (cmd == 8'hA0 || cmd == 8'h10 || cmd == 8'h30);
    rq_e = !(st_e || cmd == 8'h00 || cmd == 8'h80 || cmd == 8'h90 || cmd == 8'h98);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rd_data, e);
    check({req, " valid"}, {31'h0, rd_valid}, 32'h1);
    check("R8 stat pulse", {31'h0, stat_rd_pulse}, {31'h0, st_e});
    check("R10 reset req", {31'h0, cmd_reset_req}, {31'h0, rq_e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; rd_en = 1'b0; rd_addr = '0; rd_size = 2'd0; big_end = 1'b0;
    cur_cmd = 8'h00; status_byte = 8'h00;
    id_w0 = 16'h1234; id_w1 = 16'h22AB; id_w2 = 16'h0301; id_w3 = 16'h4455;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 data", rd_data, 32'h0);
    check("R1 valid", {31'h0, rd_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 data after release", rd_data, 32'h0);
    check("R1 flags", {29'h0, rd_valid, stat_rd_pulse, cmd_reset_req}, 32'h0);

    // R4 array sweep, two array commands
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 4; s++)
        for (int b = 0; b < 2; b++)
          do_read("R4 array", (a[0] ? 8'h80 : 8'h00), AW'(a + 16'h0300), 2'(s), b[0]);

    // R2 hold: no strobe keeps data, valid low
    held = rd_data;
    @(negedge clk);
    check("R2 hold data", rd_data, held);
    check("R2 valid low", {31'h0, rd_valid}, 32'h0);

    // R5 R6 R7 ident sweep, words without 0xFF low bytes
    for (int a = 0; a < 256; a++)
      do_read("R5 R6 R7 ident", 8'h90, AW'(a), 2'd1, a[1]);
    // R6 fallback with 0xFF low bytes
    id_w2 = 16'h12FF; id_w3 = 16'h00FF;
    for (int a = 0; a < 256; a++)
      do_read("R6 R7 ident fallback", 8'h90, AW'(a), 2'd2, a[2]);

    // R9 and R3 query sweep
    for (int a = 0; a < 256; a++) begin
      do_read("R9 query", 8'h98, AW'(a), 2'd0, 1'b0);
      check("R3 offset", {24'h0, cfi_idx}, 32'(a / 2));
    end

    // R8 status values
    for (int v = 0; v < 256; v += 37) begin
      status_byte = 8'(v);
      do_read("R8 status", 8'hA0, 16'h0010, 2'd0, 1'b0);
      do_read("R8 status", 8'h10, 16'h0011, 2'd1, 1'b1);
      do_read("R8 status", 8'h30, 16'h0012, 2'd2, 1'b0);
    end

    // R10 all command bytes
    for (int c = 0; c < 256; c++)
      do_read("R10 command sweep", 8'(c), 16'h0020, 2'd2, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule